// File: doc/BRIEF.md
# Periodic real-time interrupt timer

This block raises an interrupt at a fixed periodic rate derived from the bus clock. A free-running binary counter counts every clock from reset. A timeout is declared whenever the counter's low bits, up to a tap chosen by a two-bit rate code, are all ones. Each timeout sets a status flag. An interrupt request is raised as a level for as long as that flag and its enable bit are both set.

Software reaches the block through a small byte-wide register window with three registers. The mask register holds the enable, next to stored bits that belong to neighbouring timer functions. The flag register holds the timeout flag, which is cleared by writing a one to it. The control register holds the rate code, next to stored bits of another function. Clearing the flag never touches the counter, so the spacing between timeouts stays constant whatever the service latency. Only reset restarts the counter.

With the default base exponent of 13, the periods are 8192, 16384, 32768 and 65536 clocks. At a 2 MHz bus clock this gives 4.096 ms up to 32.768 ms. At 1 MHz it gives 8.192 ms up to 65.536 ms.

Top module: `rti_timer`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is 0.
- R2: Rate code c (control register bits 1:0) selects a period of 2^(BASE_EXP+c) clocks. With a steady code, a timeout occurs once per period and at no clock between two timeouts.
- R3: After reset is released, the flag reads 1 only after the 2^(BASE_EXP+c)-th rising clock edge, and not before it.
- R4: Clearing the flag does not move the timeout schedule. The next timeout still comes one period after the previous timeout.
- R5: The flag sits at bit 6 of the flag register (address 1). Writing a value with bit 6 = 1 clears it. Writing bit 6 = 0 leaves it unchanged. Every other bit of that register reads 0.
- R6: If a timeout and a clearing write fall on the same clock edge, the flag ends up set.
- R7: `irq` is 1 exactly while the flag is 1 and the enable (mask register bit 6, address 0) is 1. It stays 1 until one of the two is cleared.
- R8: The mask register (address 0) stores bits 7, 6, 5, 4, 1 and 0. Bits 3 and 2 always read 0.
- R9: The control register (address 2) stores bits 7:4 and the rate code in bits 1:0. Bits 3:2 read 0. Address 3 reads 0x00. The rate code changes only on a write to address 2.
- R10: A change of rate code does not reset the counter. Timeouts fall on the rising edges whose count since reset is a multiple of the newly selected period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the counter advances on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 mask, 1 flag, 2 control, 3 unmapped |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a clearing write that lands on the same edge as a timeout. The bench keeps its own count of edges since reset, so it can place a flag write exactly on a period boundary and read the flag one cycle later. Mid-period rate switches are also hard to reach. The bench writes a new code partway through a longer period and then expects the next timeout at the next multiple of the new period. A design that reset the counter on the switch would time out at a different edge.

// File: rtl/rti_pkg.sv
`timescale 1ns/1ps
package rti_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned RATE_W  = 2;
  localparam int unsigned NUM_RATES = 1 << RATE_W;
  localparam int unsigned EN_BIT  = 6;  // enable in mask reg, flag in flag reg

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam logic [DATA_W-1:0] MASK_IMPL = 8'hF3;
  localparam logic [DATA_W-1:0] CTRL_IMPL = 8'hF3;

  // timeout period in clocks for a rate code
  function automatic logic [31:0] rti_period(input int unsigned base_exp,
                                             input int unsigned code);
    return 32'd1 << (base_exp + code);
  endfunction
endpackage

// File: rtl/rti_divider.sv
`timescale 1ns/1ps
module rti_divider #(
  parameter int unsigned BASE_EXP = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [rti_pkg::RATE_W-1:0] rate,
  output logic                       tick
);
  import rti_pkg::*;
  localparam int unsigned CNT_W = BASE_EXP + NUM_RATES - 1;

  logic [CNT_W-1:0]     cnt_q;
  logic [NUM_RATES-1:0] tap_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  // one comparator per selectable tap
  for (genvar i = 0; i < NUM_RATES; i++) begin : g_tap
    assign tap_hit[i] = &cnt_q[BASE_EXP+i-1:0];
  end

  assign tick = tap_hit[rate];

  // checker: clocks since reset, saturating
  logic [31:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             since_q <= '0;
    else if (since_q != '1) since_q <= since_q + 32'd1;
  end

  AST_FIRST_FULL_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> since_q >= (rti_period(BASE_EXP, 32'(rate)) - 32'd1)); // R3
endmodule

// File: rtl/rti_flag.sv
`timescale 1ns/1ps
module rti_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (tick)    flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flag); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !tick) |=> !flag); // R5
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick)); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_req) |=> $stable(flag)); // R5
endmodule

// File: rtl/rti_regs.sv
`timescale 1ns/1ps
module rti_regs (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 addr,
  input  logic                       wr_en,
  input  logic [rti_pkg::DATA_W-1:0] wr_data,
  input  logic                       flag,
  output logic [rti_pkg::DATA_W-1:0] rd_data,
  output logic                       rti_en,
  output logic [rti_pkg::RATE_W-1:0] rate,
  output logic                       clr_req
);
  import rti_pkg::*;

  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              wr_mask, wr_ctrl;

  assign wr_mask = wr_en && (addr == ADDR_MASK);
  assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
  assign clr_req = wr_en && (addr == ADDR_FLAG) && wr_data[EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_mask) mask_q <= wr_data & MASK_IMPL;
      if (wr_ctrl) ctrl_q <= wr_data & CTRL_IMPL;
    end
  end

  assign rti_en = mask_q[EN_BIT];
  assign rate   = ctrl_q[RATE_W-1:0];

  always_comb begin
    unique case (addr)
      ADDR_MASK: rd_data = mask_q;
      ADDR_FLAG: rd_data = DATA_W'(flag) << EN_BIT;
      ADDR_CTRL: rd_data = ctrl_q;
      default:   rd_data = '0;
    endcase
  end

  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(rate)); // R9
endmodule

// File: rtl/rti_timer.sv
`timescale 1ns/1ps
module rti_timer #(
  parameter int unsigned BASE_EXP = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq
);
  import rti_pkg::*;

  logic              tick;
  logic              flag;
  logic              clr_req;
  logic              rti_en;
  logic [RATE_W-1:0] rate;

  rti_divider #(.BASE_EXP(BASE_EXP)) u_div (
    .clk(clk), .rst_n(rst_n), .rate(rate), .tick(tick));

  rti_flag u_flag (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr_req(clr_req), .flag(flag));

  rti_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .flag(flag), .rd_data(rd_data), .rti_en(rti_en), .rate(rate),
    .clr_req(clr_req));

  assign irq = flag & rti_en;

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && (addr == ADDR_MASK || addr == ADDR_FLAG))) |=> irq); // R7
  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && $stable(rti_en)) |-> $past(tick)); // R7
endmodule

// File: tb/rti_timer_tb.sv
`timescale 1ns/100ps
module rti_timer_tb;
  localparam int unsigned B = 4;  // periods 16, 32, 64, 128

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int ecnt;
  bit done = 0;

  typedef struct {
    logic [1:0] a;
    logic [7:0] d;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  rti_timer #(.BASE_EXP(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  // bench's own count of rising edges since reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  // monitor: compares one expected item per cycle
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (rd_data !== it.d) begin
          fails++;
          $display("FAIL %s: addr %0d rd_data actual %02h expected %02h (edge %0d)",
                   it.tag, it.a, rd_data, it.d, ecnt);
        end
        checks++;
        if (irq !== it.irq) begin
          fails++;
          $display("FAIL %s: irq actual %0b expected %0b (edge %0d)",
                   it.tag, irq, it.irq, ecnt);
        end
      end
    end
  end

  // driver: read check just after rising edge n
  task automatic chk_at(input int n, input logic [1:0] a, input logic [7:0] d,
                        input logic ei, input string tag);
    while (ecnt < n - 1) @(negedge clk);
    @(negedge clk);
    addr = a;
    q.push_back('{a: a, d: d, irq: ei, tag: tag});
    wait (q.size() == 0);
  endtask

  // driver: write that takes effect on rising edge n
  task automatic wr_at(input int n, input logic [1:0] a, input logic [7:0] d);
    while (ecnt < n - 1) @(negedge clk);
    addr = a;
    wr_data = d;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_at(1, 2'd0, 8'h00, 1'b0, "R1 mask reset");
    chk_at(2, 2'd1, 8'h00, 1'b0, "R1 flag reset");
    chk_at(3, 2'd2, 8'h00, 1'b0, "R1 ctrl reset");
    chk_at(4, 2'd3, 8'h00, 1'b0, "R9 unmapped address");

    wr_at(5, 2'd0, 8'hFF);
    chk_at(6, 2'd0, 8'hF3, 1'b0, "R8 mask stored bits");
    wr_at(7, 2'd0, 8'h40);

    chk_at(15, 2'd1, 8'h00, 1'b0, "R3 no flag before full period");
    chk_at(16, 2'd1, 8'h40, 1'b1, "R3 first flag after full period");
    chk_at(17, 2'd0, 8'h40, 1'b1, "R7 irq level held");
    wr_at(18, 2'd0, 8'h30);
    chk_at(19, 2'd0, 8'h30, 1'b0, "R7 enable off masks irq");

    wr_at(20, 2'd1, 8'h00);
    chk_at(21, 2'd1, 8'h40, 1'b0, "R5 write zero no effect");
    wr_at(22, 2'd1, 8'hBF);
    chk_at(23, 2'd1, 8'h40, 1'b0, "R5 other bits no effect");
    wr_at(24, 2'd0, 8'h40);
    chk_at(25, 2'd1, 8'h40, 1'b1, "R7 enable on raises irq");
    wr_at(26, 2'd1, 8'h40);
    chk_at(27, 2'd1, 8'h00, 1'b0, "R5 write one clears");

    chk_at(31, 2'd1, 8'h00, 1'b0, "R4 schedule not moved by clear");
    chk_at(32, 2'd1, 8'h40, 1'b1, "R4 timeout one period after previous");

    wr_at(48, 2'd1, 8'h40);
    chk_at(49, 2'd1, 8'h40, 1'b1, "R6 timeout wins over clear");
    wr_at(50, 2'd1, 8'h40);
    chk_at(51, 2'd1, 8'h00, 1'b0, "R5 clear after collision");

    wr_at(52, 2'd2, 8'hFD);
    chk_at(53, 2'd2, 8'hF1, 1'b0, "R9 ctrl stored bits");
    chk_at(63, 2'd1, 8'h00, 1'b0, "R2 rate 01 no early timeout");
    chk_at(64, 2'd1, 8'h40, 1'b1, "R2 rate 01 timeout");
    wr_at(65, 2'd1, 8'h40);
    chk_at(80, 2'd1, 8'h00, 1'b0, "R2 rate 01 none at half period");
    chk_at(95, 2'd1, 8'h00, 1'b0, "R2 rate 01 before period");
    chk_at(96, 2'd1, 8'h40, 1'b1, "R2 rate 01 period 32");

    wr_at(97, 2'd1, 8'h40);
    wr_at(98, 2'd2, 8'h02);
    chk_at(99, 2'd2, 8'h02, 1'b0, "R9 rate code written");
    chk_at(112, 2'd1, 8'h00, 1'b0, "R2 rate 10 none at 112");
    chk_at(127, 2'd1, 8'h00, 1'b0, "R2 rate 10 before period");
    chk_at(128, 2'd1, 8'h40, 1'b1, "R2 rate 10 period 64");

    wr_at(129, 2'd1, 8'h40);
    wr_at(130, 2'd2, 8'h03);
    chk_at(192, 2'd1, 8'h00, 1'b0, "R2 rate 11 none at 192");
    chk_at(255, 2'd1, 8'h00, 1'b0, "R2 rate 11 before period");
    chk_at(256, 2'd1, 8'h40, 1'b1, "R2 rate 11 period 128");

    wr_at(257, 2'd1, 8'h40);
    wr_at(260, 2'd2, 8'h00);
    chk_at(271, 2'd1, 8'h00, 1'b0, "R10 switch mid period not early");
    chk_at(272, 2'd1, 8'h40, 1'b1, "R10 switch keeps counter phase");

    // second reset restarts everything
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_at(1, 2'd0, 8'h00, 1'b0, "R1 mask after re-reset");
    chk_at(2, 2'd2, 8'h00, 1'b0, "R1 ctrl after re-reset");
    chk_at(3, 2'd1, 8'h00, 1'b0, "R1 flag after re-reset");
    wr_at(4, 2'd0, 8'h40);
    chk_at(15, 2'd1, 8'h00, 1'b0, "R3 re-reset no early flag");
    chk_at(16, 2'd1, 8'h40, 1'b1, "R3 re-reset full period");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule